// File: doc/BRIEF.md
# Clock Source Bring-Up Sequencer

This block runs in a control clock domain and brings a frequency-synthesizer clock path up from a chosen reference. A one-cycle start pulse captures a source request. The sequencer then holds the synthesizer in reset and programs the reference mux while the reset is held. It releases the reset and waits a fixed settling time of one millisecond, measured in control-clock cycles. At the end of that time it samples the synthesizer lock indicator once. The lock indicator arrives from a foreign clock domain, so a synchronizer carries it into the control domain before it is used.

If lock is present, the sequencer asserts the downstream PHY reset as its last step and reports done. If lock is absent, it reports a failure and takes no further action. Both outcomes stay flagged until the next accepted start. The block also produces the reset for the generated clock domain. That reset asserts at once whenever lock is low and releases synchronously to the generated clock.

The physical mux select pin has inverted polarity: a low level on that pin picks the second (external) input. The pin therefore carries the complement of the stored select bit.

Top module: `clk_bringup_seq`

## Requirements
- R1: After reset: synthRst=1, phyRst=0, done=0, failed=0, busy=0, and refSelPin=1 (the stored select bit resets to 0, meaning internal).
- R2: srcCode is captured on the edge that accepts a start. The codes are 0=unset, 1=internal, 2=external and 3=unrecognized. Only code 2 stores select bit 1 (external); every other code stores 0 (internal).
- R3: refSelPin always equals the inverse of the stored select bit. It changes only while synthRst is high.
- R4: Edge numbering counts from E0, the edge that accepts start. synthRst is high after E0. refSelPin takes the new select value after E1 while synthRst is still high. synthRst goes low after E2.
- R5: The outcome appears after edge E(W+3), where W = CYCLES_PER_MS. lock passes through a 2-stage synchronizer, so the value that decides the outcome is synthLock as sampled at edge E(W+1).
- R6: When lock is seen, done=1 and phyRst=1, and synthRst stays low.
- R7: When lock is not seen, failed=1 and phyRst stays 0. These stay in place with no further sequencing.
- R8: done and failed are sticky until the next accepted start, which clears both (and phyRst) at E0. They are never high together.
- R9: A start pulse while busy=1 is ignored. The sequence, the select pin and the outcome timing are unchanged.
- R10: genRst goes to 1 asynchronously whenever synthLock is 0. It returns to 0 after 2 rising genClk edges while synthLock is 1.
- R11: busy is 1 from E0 until the outcome edge E(W+3), and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control-domain clock |
| rstN | input | 1 | Asynchronous active-low control reset |
| startPulse | input | 1 | One-cycle request to begin bring-up |
| srcCode | input | 2 | Reference request code (0 unset, 1 internal, 2 external, 3 unrecognized) |
| synthLock | input | 1 | Lock indicator from the synthesizer, asynchronous |
| genClk | input | 1 | Generated clock from the synthesizer |
| synthRst | output | 1 | Synthesizer reset, active high |
| refSelPin | output | 1 | Reference mux select pin, inverted polarity |
| phyRst | output | 1 | Downstream PHY reset, asserted as the final step |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sticky success flag |
| failed | output | 1 | Sticky lock-failure flag |
| genRst | output | 1 | Reset for the generated clock domain |

## Verification
Each result has a fixed due cycle counted from E0. The bench records E0 for each accepted start and drives inputs on falling edges. Ordering is checked at the falling edges after E0, E1 and E2 (busy, the select pin under reset, then reset release). The outcome flags are checked exactly W+3 edges after E0. The synthesizer model raises lock a set number of edges after the reset is released. Its two boundary settings put the lock just before and just after the sampling edge E(W+1). The generated-domain reset is checked once lock drops, and again after three generated-clock edges.

// File: rtl/clkup_pkg.sv
package clkup_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SELECT,
    ST_RELEASE,
    ST_WAIT,
    ST_CHECK,
    ST_DONE,
    ST_FAIL
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic setRst;
    logic loadSel;
    logic clrRst;
    logic clrCnt;
    logic incCnt;
    logic setPhy;
    logic clrPhy;
  } dpStrobe_t;

  localparam logic [1:0] SRC_UNSET = 2'd0;
  localparam logic [1:0] SRC_INT   = 2'd1;
  localparam logic [1:0] SRC_EXT   = 2'd2;

  // only the explicit external code selects the second reference
  function automatic logic decodeSrc(input logic [1:0] code);
    return (code == SRC_EXT);
  endfunction

endpackage

// File: rtl/clkup_datapath.sv
module clkup_datapath
  import clkup_pkg::*;
#(
  parameter int CYCLES_PER_MS = 100000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  stb,
  input  logic [1:0] srcCode,
  input  logic       synthLock,
  output logic       synthRst,
  output logic       selBit,
  output logic       phyRst,
  output logic       cntDone,
  output logic       lockSync
);

  localparam int WAIT_CYCLES = CYCLES_PER_MS;
  localparam int CNT_W       = $clog2(WAIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYCLES - 1);

  logic [1:0]       reqReg;
  logic [CNT_W-1:0] waitCnt;
  logic [SYNC_STAGES-1:0] syncReg;

  // synthesizer reset: held from reset until explicitly released
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            synthRst <= 1'b1;
    else if (stb.setRst)  synthRst <= 1'b1;
    else if (stb.clrRst)  synthRst <= 1'b0;
  end

  // request captured with the start, decoded one cycle later
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqReg <= SRC_UNSET;
      selBit <= 1'b0;
    end else begin
      if (stb.setRst)  reqReg <= srcCode;
      if (stb.loadSel) selBit <= decodeSrc(reqReg);
    end
  end

  // settling delay counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            waitCnt <= '0;
    else if (stb.clrCnt)  waitCnt <= '0;
    else if (stb.incCnt)  waitCnt <= waitCnt + 1'b1;
  end

  assign cntDone = (waitCnt == CNT_LAST);

  // PHY reset raised as the last bring-up step
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            phyRst <= 1'b0;
    else if (stb.clrPhy)  phyRst <= 1'b0;
    else if (stb.setPhy)  phyRst <= 1'b1;
  end

  // lock synchronizer into the control domain
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg <= '0;
        else       syncReg <= synthLock;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg <= '0;
        else       syncReg <= {syncReg[SYNC_STAGES-2:0], synthLock};
      end
    end
  endgenerate

  assign lockSync = syncReg[SYNC_STAGES-1];

endmodule

// File: rtl/clkup_ctrl.sv
module clkup_ctrl
  import clkup_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startPulse,
  input  logic      cntDone,
  input  logic      lockSync,
  output dpStrobe_t stb,
  output logic      busy,
  output logic      done,
  output logic      failed
);

  seqState_t curState, nxtState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_IDLE;
    else       curState <= nxtState;
  end

  always_comb begin
    nxtState = curState;
    stb      = '0;
    unique case (curState)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (startPulse) begin
          stb.setRst = 1'b1;
          stb.clrPhy = 1'b1;
          nxtState   = ST_SELECT;
        end
      end
      ST_SELECT: begin
        stb.loadSel = 1'b1;
        nxtState    = ST_RELEASE;
      end
      ST_RELEASE: begin
        stb.clrRst = 1'b1;
        stb.clrCnt = 1'b1;
        nxtState   = ST_WAIT;
      end
      ST_WAIT: begin
        stb.incCnt = 1'b1;
        if (cntDone) nxtState = ST_CHECK;
      end
      ST_CHECK: begin
        if (lockSync) begin
          stb.setPhy = 1'b1;
          nxtState   = ST_DONE;
        end else begin
          nxtState   = ST_FAIL;
        end
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  assign done   = (curState == ST_DONE);
  assign failed = (curState == ST_FAIL);
  assign busy   = !(curState == ST_IDLE || curState == ST_DONE || curState == ST_FAIL);

endmodule

// File: rtl/clkup_genrst.sv
module clkup_genrst #(
  parameter int STAGES = 2
) (
  input  logic genClk,
  input  logic synthLock,
  output logic genRst
);

  logic [STAGES-1:0] shReg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge genClk or negedge synthLock) begin
        if (!synthLock) shReg <= '1;
        else            shReg <= '0;
      end
    end else begin : g_many
      always_ff @(posedge genClk or negedge synthLock) begin
        if (!synthLock) shReg <= '1;
        else            shReg <= {shReg[STAGES-2:0], 1'b0};
      end
    end
  endgenerate

  assign genRst = shReg[STAGES-1];

endmodule

// File: rtl/clk_bringup_seq.sv
module clk_bringup_seq
  import clkup_pkg::*;
#(
  parameter int CYCLES_PER_MS  = 100000,
  parameter int SYNC_STAGES    = 2,
  parameter int GEN_RST_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic [1:0] srcCode,
  input  logic       synthLock,
  input  logic       genClk,
  output logic       synthRst,
  output logic       refSelPin,
  output logic       phyRst,
  output logic       busy,
  output logic       done,
  output logic       failed,
  output logic       genRst
);

  dpStrobe_t stb;
  logic      selBit;
  logic      cntDone;
  logic      lockSync;

  clkup_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .cntDone    (cntDone),
    .lockSync   (lockSync),
    .stb        (stb),
    .busy       (busy),
    .done       (done),
    .failed     (failed)
  );

  clkup_datapath #(
    .CYCLES_PER_MS (CYCLES_PER_MS),
    .SYNC_STAGES   (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .srcCode   (srcCode),
    .synthLock (synthLock),
    .synthRst  (synthRst),
    .selBit    (selBit),
    .phyRst    (phyRst),
    .cntDone   (cntDone),
    .lockSync  (lockSync)
  );

  clkup_genrst #(
    .STAGES (GEN_RST_STAGES)
  ) u_genrst (
    .genClk    (genClk),
    .synthLock (synthLock),
    .genRst    (genRst)
  );

  // a low level on the mux pin picks the second (external) input
  assign refSelPin = ~selBit;

endmodule

// File: rtl/clkup_checker.sv
module clkup_checker (
  input logic clk,
  input logic rstN,
  input logic startPulse,
  input logic synthLock,
  input logic synthRst,
  input logic refSelPin,
  input logic phyRst,
  input logic busy,
  input logic done,
  input logic failed,
  input logic genRst
);

  p_sel_under_rst_r3: assert property (@(posedge clk) disable iff (!rstN)
    !synthRst |-> $stable(refSelPin));

  p_release_in_seq_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(synthRst) |-> busy);

  p_phy_with_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    phyRst |-> (done && !synthRst));

  p_fail_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (failed && !startPulse) |=> (failed && !phyRst));

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !startPulse) |=> done);

  p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(done && failed));

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !synthRst && startPulse) |=> !synthRst);

  p_genrst_lowlock_r10: assert property (@(posedge clk) disable iff (!rstN)
    !synthLock |-> genRst);

endmodule

bind clk_bringup_seq clkup_checker u_clkup_checker (
  .clk        (clk),
  .rstN       (rstN),
  .startPulse (startPulse),
  .synthLock  (synthLock),
  .synthRst   (synthRst),
  .refSelPin  (refSelPin),
  .phyRst     (phyRst),
  .busy       (busy),
  .done       (done),
  .failed     (failed),
  .genRst     (genRst)
);

// File: tb/clk_bringup_seq_bench.sv
module clk_bringup_seq_bench;

  localparam int W = 20;

  logic       clk = 1'b0;
  logic       genClk = 1'b0;
  logic       rstN = 1'b0;
  logic       startPulse = 1'b0;
  logic [1:0] srcCode = 2'd0;
  logic       synthLock = 1'b0;
  logic       synthRst, refSelPin, phyRst, busy, done, failed, genRst;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lockDelay = 5;
  int lockCnt = 0;
  bit finished = 1'b0;

  typedef struct {
    bit    expFail;
    bit    expSel;
    int    startCyc;
    string req;
  } expItem_t;

  expItem_t sbQ[$];

  clk_bringup_seq #(.CYCLES_PER_MS(W)) u_clk_bringup_seq (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .srcCode(srcCode),
    .synthLock(synthLock), .genClk(genClk), .synthRst(synthRst),
    .refSelPin(refSelPin), .phyRst(phyRst), .busy(busy), .done(done),
    .failed(failed), .genRst(genRst)
  );

  always #2 clk = ~clk;
  always #3 genClk = ~genClk;

  always @(posedge clk) cyc <= cyc + 1;

  // synthesizer model: lock rises lockDelay+1 edges after reset release
  always @(posedge clk) begin
    if (synthRst) begin
      lockCnt   <= 0;
      synthLock <= 1'b0;
    end else if (lockCnt == lockDelay) begin
      synthLock <= 1'b1;
    end else begin
      lockCnt <= lockCnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // driver: pulse start on a falling edge and queue the expected outcome
  task automatic pushStart(input logic [1:0] code, input bit expFail, input string req);
    expItem_t it;
    @(negedge clk);
    srcCode    = code;
    startPulse = 1'b1;
    it.expFail  = expFail;
    it.expSel   = (code == 2'd2);
    it.startCyc = cyc + 1;
    it.req      = req;
    sbQ.push_back(it);
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic waitOutcome();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: compare each outcome when a flag rises
  bit prevFlag = 1'b0;
  always @(negedge clk) begin
    if (rstN && (done || failed) && !prevFlag) begin
      if (sbQ.size() == 0) begin
        chk(1'b0, "R9 unexpected outcome", 1, 0);
      end else begin
        expItem_t it;
        it = sbQ.pop_front();
        chk((cyc - it.startCyc) == W + 3, {it.req, " R5 latency"}, cyc - it.startCyc, W + 3);
        chk(failed == it.expFail, {it.req, " R6/R7 outcome failed"}, failed, it.expFail);
        chk(done == !it.expFail, {it.req, " R6 done"}, done, !it.expFail);
        chk(phyRst == !it.expFail, {it.req, " R6/R7 phyRst"}, phyRst, !it.expFail);
        chk(refSelPin == !it.expSel, {it.req, " R2/R3 refSelPin"}, refSelPin, !it.expSel);
        chk(synthRst == 1'b0, {it.req, " R7 synthRst stays released"}, synthRst, 0);
      end
    end
    prevFlag = rstN && (done || failed);
  end

  initial begin
    #200000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(synthRst == 1'b1, "R1 synthRst", synthRst, 1);
    chk(phyRst == 1'b0, "R1 phyRst", phyRst, 0);
    chk({done, failed, busy} == 3'b000, "R1 flags", {done, failed, busy}, 0);
    chk(refSelPin == 1'b1, "R1 refSelPin", refSelPin, 1);
    chk(genRst == 1'b1, "R10 genRst with no lock", genRst, 1);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(synthRst == 1'b1, "R1 synthRst held without start", synthRst, 1);

    // unset code -> internal, lock in time
    lockDelay = 5;
    pushStart(2'd0, 1'b0, "R2 unset");
    chk(busy == 1'b1, "R11 busy after E0", busy, 1);
    waitOutcome();
    repeat (3) @(posedge genClk);
    @(negedge clk);
    chk(genRst == 1'b0, "R10 genRst released", genRst, 0);
    repeat (5) @(negedge clk);
    chk(done == 1'b1, "R8 done sticky", done, 1);

    // external: ordering at E0, E1, E2
    lockDelay = 5;
    pushStart(2'd2, 1'b0, "R2 external");
    chk(done == 1'b0, "R8 done cleared at E0", done, 0);
    chk(synthRst == 1'b1, "R4 synthRst after E0", synthRst, 1);
    chk(refSelPin == 1'b1, "R4 select unchanged after E0", refSelPin, 1);
    @(negedge clk);
    chk(refSelPin == 1'b0, "R3 R4 select driven after E1", refSelPin, 0);
    chk(synthRst == 1'b1, "R4 synthRst still high after E1", synthRst, 1);
    chk(synthLock == 1'b0 && genRst == 1'b1, "R10 genRst on lock loss", genRst, 1);
    @(negedge clk);
    chk(synthRst == 1'b0, "R4 synthRst released after E2", synthRst, 0);
    waitOutcome();

    // unrecognized -> internal
    lockDelay = 5;
    pushStart(2'd3, 1'b0, "R2 unrecognized");
    waitOutcome();

    // boundary: lock high just before the sampling edge
    lockDelay = W - 3;
    pushStart(2'd1, 1'b0, "R5 boundary in time");
    waitOutcome();

    // boundary: lock one edge too late
    lockDelay = W - 2;
    pushStart(2'd2, 1'b1, "R5 R7 boundary late");
    waitOutcome();
    repeat (10) @(negedge clk);
    chk(failed == 1'b1, "R7 failed sticky", failed, 1);
    chk(phyRst == 1'b0, "R7 phyRst stays low", phyRst, 0);
    chk(busy == 1'b0, "R7 no further steps", busy, 0);

    // far too late
    lockDelay = 3 * W;
    pushStart(2'd1, 1'b1, "R7 no lock");
    waitOutcome();

    // start while busy is ignored
    lockDelay = 5;
    pushStart(2'd1, 1'b0, "R9 busy run");
    repeat (6) @(negedge clk);
    srcCode    = 2'd2;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    chk(synthRst == 1'b0, "R9 synthRst not reasserted", synthRst, 0);
    repeat (3) @(negedge clk);
    chk(refSelPin == 1'b1, "R9 select unchanged", refSelPin, 1);
    waitOutcome();
    repeat (4) @(negedge clk);
    chk(sbQ.size() == 0, "R9 scoreboard drained", sbQ.size(), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule